// File: doc/BRIEF.md
# Floppy Write and Erase Gate Timer

This block sits between a disk controller's write command lines and a drive's write electronics. It qualifies an active-low write request with unit selection, the media's protect state and a supply-good indication, and turns it into an internal write strobe. From that strobe it derives a write-busy window, a delayed erase enable and a pair of alternating write-current phase outputs. The phase outputs flip on every falling edge of the serial write-data line.

Erase turns on a fixed time after writing begins. After writing stops, erase and write-busy stay on for a hold time that restarts on every write-data falling edge. While write-busy is high the read path is switched off. A sticky status bit records a write-data edge that arrives too soon after the write starts. All delays are given in microseconds and converted to clock cycles from a clock-frequency parameter. The inputs are taken as synchronous to the block clock.

Top module: `flop_write_gate`

## Requirements
- R1: `intWrite` is high in a cycle exactly when, at the previous clock edge, `wrEnN` was 0, `unitSelN` was 0, `wrProtN` was 1 (not protected) and `powerGood` was 1.
- R2: `eraseEn` first rises exactly ON cycles after `intWrite` rises, if `intWrite` stays high that long. ON is ERASE_ON_US times cycles-per-microsecond.
- R3: A write whose `intWrite` high time is shorter than ON cycles never raises `eraseEn`, neither during the write nor during the hold that follows.
- R4: After `intWrite` falls with no further write-data edges, `wrBusy` stays high for exactly HOLD cycles and then drops. HOLD is ERASE_HOLD_US times cycles-per-microsecond. An armed erase follows `wrBusy` and drops with it.
- R5: A write-data falling edge is a `wrDataN` sample of 1 followed by a sample of 0. When one is sampled while `wrBusy` is high, the hold restarts, so `wrBusy` stays high for HOLD cycles after that edge. The same edge has no effect once `wrBusy` is low.
- R6: Each write-data falling edge sampled while `wrBusy` is high flips the write phase. While `intWrite` is high exactly one of `phaseA`/`phaseB` is high, with `phaseA` high for an even number of flips since reset or power loss. Both are low while `intWrite` is low.
- R7: `readEn` is the inverse of `wrBusy` in every cycle.
- R8: A cycle with `powerGood` low clears `intWrite`, `wrBusy`, `eraseEn`, the write phase and `earlyFlag` at the next edge. After power returns, the first write starts on `phaseA`.
- R9: `earlyFlag` sets when a write-data falling edge is sampled j clock edges after `intWrite` rose, with 1 <= j < EARLY (EARLY is EARLY_US in cycles). It stays set until the next write starts. Edges at j >= EARLY, or at the edge where `intWrite` rises, do not set it.
- R10: A rising edge on `wrDataN` leaves the write phase unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEnN | input | 1 | Write request from controller, active low |
| unitSelN | input | 1 | Unit select, active low |
| wrProtN | input | 1 | Media protect sense, low when protected |
| powerGood | input | 1 | Supply good, high when the 5 V rail is valid |
| wrDataN | input | 1 | Serial write data; falling edges mark flux changes |
| intWrite | output | 1 | Qualified internal write |
| wrBusy | output | 1 | Write period including the erase hold |
| eraseEn | output | 1 | Erase driver enable |
| phaseA | output | 1 | Write-current direction A |
| phaseB | output | 1 | Write-current direction B |
| readEn | output | 1 | Read path enable, low during write-busy |
| earlyFlag | output | 1 | Sticky flag for a write-data edge arriving too soon |

## Verification
A miscounted on-delay shows at `eraseEn` in the first write longer than the delay, one cycle early or late against the computed edge. A wrong hold count or a missed retrigger shifts the falling edge of `wrBusy` and `readEn` within HOLD cycles of the last write-data edge. A phase flip-flop that toggles on the wrong edge, or that survives power loss, swaps `phaseA` and `phaseB` on the next sampled pulse. The bench sweeps write length, retrigger offset and early-pulse offset across every value around each boundary of a small timing configuration.

// File: rtl/fwg_pkg.sv
package fwg_pkg;

  // Strobes passed from the control half to the timing datapath
  typedef struct packed {
    logic wrActive;   // registered qualified write
    logic wrStart;    // first cycle of a write
    logic dataFall;   // write-data falling edge seen this cycle
    logic clrAll;     // supply not good: flush all state
  } wgStrobe_t;

  // Microseconds to clock cycles, never below one cycle
  function automatic int usToCycles(input int clkHz, input int us);
    int cyc;
    cyc = ((clkHz / 1000) * us) / 1000;
    return (cyc < 1) ? 1 : cyc;
  endfunction

endpackage

// File: rtl/fwg_ctrl.sv
module fwg_ctrl
  import fwg_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEnN,
  input  logic       unitSelN,
  input  logic       wrProtN,
  input  logic       powerGood,
  input  logic       wrDataN,
  output wgStrobe_t  strobe,
  output logic       intWrite
);

  logic wrGo;
  logic wrActQ;
  logic startQ;
  logic dataQ;

  // Write is refused unless selected, unprotected and powered
  assign wrGo = !wrEnN && !unitSelN && wrProtN && powerGood;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrActQ <= 1'b0;
      startQ <= 1'b0;
      dataQ  <= 1'b1;
    end else begin
      wrActQ <= wrGo;
      startQ <= wrGo && !wrActQ;
      dataQ  <= wrDataN;
    end
  end

  always_comb begin
    strobe.wrActive = wrActQ;
    strobe.wrStart  = startQ;
    strobe.dataFall = dataQ && !wrDataN;
    strobe.clrAll   = !powerGood;
  end

  assign intWrite = wrActQ;

  // R1: internal write only follows a fully qualified request
  p_gate_r1: assert property (@(posedge clk) disable iff (!rstN)
    intWrite |-> $past(!wrEnN && !unitSelN && wrProtN && powerGood));

  // R9: start strobe marks only the first write cycle
  p_start_r9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrStart |-> (strobe.wrActive && !$past(strobe.wrActive)));

endmodule

// File: rtl/fwg_datapath.sv
module fwg_datapath
  import fwg_pkg::*;
#(
  parameter int ON_CYC    = 3120,
  parameter int HOLD_CYC  = 7200,
  parameter int EARLY_CYC = 32
)(
  input  logic      clk,
  input  logic      rstN,
  input  wgStrobe_t strobe,
  output logic      wrBusy,
  output logic      eraseEn,
  output logic      writePhase,
  output logic      earlyFlag
);

  localparam int CNT_MAX = (ON_CYC > EARLY_CYC) ? ON_CYC : EARLY_CYC;
  localparam int ON_W    = $clog2(CNT_MAX + 1);
  localparam int HOLD_W  = $clog2(HOLD_CYC + 1);

  localparam logic [ON_W-1:0]   CNT_TOP   = ON_W'(CNT_MAX);
  localparam logic [ON_W-1:0]   ON_LAST   = ON_W'(ON_CYC - 1);
  localparam logic [ON_W-1:0]   ON_FULL   = ON_W'(ON_CYC);
  localparam logic [ON_W-1:0]   EARLY_LIM = ON_W'(EARLY_CYC - 1);
  localparam logic [HOLD_W-1:0] HOLD_LOAD = HOLD_W'(HOLD_CYC);

  logic [ON_W-1:0]   onCnt;
  logic [HOLD_W-1:0] holdCnt;
  logic              eraseArmed;
  logic              togQ;
  logic              earlyQ;
  logic              holdLive;

  assign holdLive = (holdCnt != '0);
  assign wrBusy   = strobe.wrActive || holdLive;

  // Time since write start, saturating
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      onCnt <= '0;
    end else if (strobe.clrAll || !strobe.wrActive) begin
      onCnt <= '0;
    end else if (onCnt != CNT_TOP) begin
      onCnt <= onCnt + 1'b1;
    end
  end

  // Retriggerable erase hold
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdCnt <= '0;
    end else if (strobe.clrAll) begin
      holdCnt <= '0;
    end else if (strobe.wrActive) begin
      holdCnt <= HOLD_LOAD;
    end else if (strobe.dataFall && holdLive) begin
      holdCnt <= HOLD_LOAD;
    end else if (holdLive) begin
      holdCnt <= holdCnt - 1'b1;
    end
  end

  // Erase arms once the on-delay completes, disarms when busy ends
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      eraseArmed <= 1'b0;
    end else if (strobe.clrAll) begin
      eraseArmed <= 1'b0;
    end else if (strobe.wrActive && (onCnt == ON_LAST)) begin
      eraseArmed <= 1'b1;
    end else if (!wrBusy) begin
      eraseArmed <= 1'b0;
    end
  end

  assign eraseEn = eraseArmed && wrBusy;

  // Write-current direction flip-flop, enabled by write-busy
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      togQ <= 1'b0;
    end else if (strobe.clrAll) begin
      togQ <= 1'b0;
    end else if (strobe.dataFall && wrBusy) begin
      togQ <= ~togQ;
    end
  end

  assign writePhase = togQ;

  // Sticky too-soon data edge flag
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      earlyQ <= 1'b0;
    end else if (strobe.clrAll) begin
      earlyQ <= 1'b0;
    end else if (strobe.dataFall && strobe.wrActive && (onCnt < EARLY_LIM)) begin
      earlyQ <= 1'b1;
    end else if (strobe.wrStart) begin
      earlyQ <= 1'b0;
    end
  end

  assign earlyFlag = earlyQ;

  // R2: erase comes on only when the on-delay has fully elapsed
  p_erase_rise_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(eraseEn) |-> (onCnt == ON_FULL));

  // R4: idle hold counts down one per cycle
  p_hold_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.wrActive && holdLive && !strobe.dataFall && !strobe.clrAll)
      |=> (holdCnt == $past(holdCnt) - 1'b1));

  // R6: a qualified data edge flips the phase
  p_toggle_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.dataFall && wrBusy && !strobe.clrAll) |=> (togQ != $past(togQ)));

  // R8: loss of supply flushes busy and erase
  p_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clrAll |=> (!wrBusy && !eraseEn && !togQ));

  // R9: flag rises only on a too-soon edge inside a write
  p_early_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(earlyQ) |-> $past(strobe.dataFall && strobe.wrActive && (onCnt < EARLY_LIM)));

endmodule

// File: rtl/flop_write_gate.sv
module flop_write_gate
  import fwg_pkg::*;
#(
  parameter int CLK_HZ        = 8_000_000,
  parameter int ERASE_ON_US   = 390,
  parameter int ERASE_HOLD_US = 900,
  parameter int EARLY_US      = 4
)(
  input  logic clk,
  input  logic rstN,
  input  logic wrEnN,
  input  logic unitSelN,
  input  logic wrProtN,
  input  logic powerGood,
  input  logic wrDataN,
  output logic intWrite,
  output logic wrBusy,
  output logic eraseEn,
  output logic phaseA,
  output logic phaseB,
  output logic readEn,
  output logic earlyFlag
);

  localparam int ON_CYC    = usToCycles(CLK_HZ, ERASE_ON_US);
  localparam int HOLD_CYC  = usToCycles(CLK_HZ, ERASE_HOLD_US);
  localparam int EARLY_CYC = usToCycles(CLK_HZ, EARLY_US);

  wgStrobe_t strobe;
  logic      writePhase;

  fwg_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .wrEnN     (wrEnN),
    .unitSelN  (unitSelN),
    .wrProtN   (wrProtN),
    .powerGood (powerGood),
    .wrDataN   (wrDataN),
    .strobe    (strobe),
    .intWrite  (intWrite)
  );

  fwg_datapath #(
    .ON_CYC    (ON_CYC),
    .HOLD_CYC  (HOLD_CYC),
    .EARLY_CYC (EARLY_CYC)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .wrBusy     (wrBusy),
    .eraseEn    (eraseEn),
    .writePhase (writePhase),
    .earlyFlag  (earlyFlag)
  );

  assign phaseA = intWrite && !writePhase;
  assign phaseB = intWrite && writePhase;
  assign readEn = !wrBusy;

endmodule

// File: tb/flop_write_gate_tb_top.sv
module flop_write_gate_tb_top;

  localparam int ON    = 20;
  localparam int HOLD  = 30;
  localparam int EARLY = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rstN, wrEnN, unitSelN, wrProtN, powerGood, wrDataN;
  logic intWrite, wrBusy, eraseEn, phaseA, phaseB, readEn, earlyFlag;

  int nRun  = 0;
  int nFail = 0;

  flop_write_gate #(
    .CLK_HZ        (1_000_000),
    .ERASE_ON_US   (ON),
    .ERASE_HOLD_US (HOLD),
    .EARLY_US      (EARLY)
  ) dut_i (
    .clk       (clk),
    .rstN      (rstN),
    .wrEnN     (wrEnN),
    .unitSelN  (unitSelN),
    .wrProtN   (wrProtN),
    .powerGood (powerGood),
    .wrDataN   (wrDataN),
    .intWrite  (intWrite),
    .wrBusy    (wrBusy),
    .eraseEn   (eraseEn),
    .phaseA    (phaseA),
    .phaseB    (phaseB),
    .readEn    (readEn),
    .earlyFlag (earlyFlag)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle(input int n);
    wrEnN = 1'b1;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    int riseAt;
    int dl[5];
    rstN = 1'b0; wrEnN = 1'b1; unitSelN = 1'b0; wrProtN = 1'b1;
    powerGood = 1'b1; wrDataN = 1'b1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // reset state
    chk("R1 reset intWrite", intWrite, 0);
    chk("R4 reset wrBusy", wrBusy, 0);
    chk("R3 reset eraseEn", eraseEn, 0);
    chk("R6 reset phases", int'(phaseA) + int'(phaseB), 0);
    chk("R7 reset readEn", readEn, 1);
    chk("R9 reset earlyFlag", earlyFlag, 0);

    // R1: every combination of the four qualifiers
    for (int m = 0; m < 16; m++) begin
      wrEnN = m[0]; unitSelN = m[1]; wrProtN = m[2]; powerGood = m[3];
      @(negedge clk);
      chk("R1 gate", intWrite, (m == 12) ? 1 : 0);
      chk("R6 phase count", int'(phaseA) + int'(phaseB), (m == 12) ? 1 : 0);
    end
    unitSelN = 1'b0; wrProtN = 1'b1; powerGood = 1'b1;
    idle(ON + HOLD + 5);

    // R2 R3 R4 R7: sweep write length around the on-delay
    for (int L = 1; L <= ON + 3; L++) begin
      wrEnN = 1'b0;
      riseAt = 0;
      for (int c = 1; c <= L; c++) begin
        @(negedge clk);
        chk("R1 held", intWrite, 1);
        if (eraseEn && riseAt == 0) riseAt = c;
      end
      chk("R2 erase rise cycle", riseAt, (L > ON) ? ON + 1 : 0);
      wrEnN = 1'b1;
      for (int c = 1; c <= HOLD + 2; c++) begin
        @(negedge clk);
        chk("R4 busy hold", wrBusy, (c <= HOLD) ? 1 : 0);
        chk((L >= ON) ? "R4 erase hold" : "R3 no erase", eraseEn,
            (L >= ON && c <= HOLD) ? 1 : 0);
        chk("R7 readEn", readEn, (c <= HOLD) ? 0 : 1);
      end
      idle(2);
    end

    // R5: retrigger offsets, including one just after busy ends
    dl[0] = 1; dl[1] = HOLD / 2; dl[2] = HOLD - 1; dl[3] = HOLD; dl[4] = HOLD + 1;
    for (int i = 0; i < 5; i++) begin
      wrEnN = 1'b0;
      repeat (ON + 2) @(negedge clk);
      wrEnN = 1'b1;
      for (int c = 1; c <= dl[i] + HOLD + 2; c++) begin
        @(negedge clk);
        chk("R5 busy retrigger", wrBusy,
            ((dl[i] <= HOLD) ? (c <= dl[i] + HOLD) : (c <= HOLD)) ? 1 : 0);
        chk("R5 erase retrigger", eraseEn,
            ((dl[i] <= HOLD) ? (c <= dl[i] + HOLD) : (c <= HOLD)) ? 1 : 0);
        if (c == dl[i]) wrDataN = 1'b0;
        if (c == dl[i] + 1) wrDataN = 1'b1;
      end
      idle(3);
    end

    // R9: data edge offset sweep after write start
    for (int jp = 0; jp <= EARLY + 2; jp++) begin
      wrEnN = 1'b0;
      if (jp == 0) wrDataN = 1'b0;
      for (int c = 1; c <= EARLY + 4; c++) begin
        @(negedge clk);
        if (c == ((jp < 1) ? 1 : jp) + 1)
          chk("R9 early flag", earlyFlag, (jp >= 1 && jp < EARLY) ? 1 : 0);
        if (jp > 0 && c == jp) wrDataN = 1'b0;
        if (c == jp + 1) wrDataN = 1'b1;
      end
      idle(HOLD + 3);
      chk("R9 flag sticky", earlyFlag, (jp >= 1 && jp < EARLY) ? 1 : 0);
    end

    // R8: power loss in the middle of an erasing write
    wrEnN = 1'b0;
    for (int c = 1; c <= ON + 2; c++) begin
      @(negedge clk);
      if (c == 2) wrDataN = 1'b0;
      if (c == 3) wrDataN = 1'b1;
    end
    chk("R2 erase on before power loss", eraseEn, 1);
    powerGood = 1'b0;
    @(negedge clk);
    chk("R8 intWrite", intWrite, 0);
    chk("R8 wrBusy", wrBusy, 0);
    chk("R8 eraseEn", eraseEn, 0);
    chk("R8 phases", int'(phaseA) + int'(phaseB), 0);
    chk("R8 earlyFlag", earlyFlag, 0);
    repeat (3) @(negedge clk);
    chk("R8 busy stays low", wrBusy, 0);
    powerGood = 1'b1;
    @(negedge clk);
    chk("R8 write resumes", intWrite, 1);
    chk("R8 phaseA after restore", phaseA, 1);
    chk("R8 phaseB after restore", phaseB, 0);

    // R6 R10: falling edges flip, rising edges do not
    for (int n = 1; n <= 5; n++) begin
      wrDataN = 1'b0;
      @(negedge clk);
      chk("R6 phaseA", phaseA, (n % 2 == 0) ? 1 : 0);
      chk("R6 phaseB", phaseB, (n % 2 == 0) ? 0 : 1);
      wrDataN = 1'b1;
      @(negedge clk);
      chk("R10 rising edge", phaseA, (n % 2 == 0) ? 1 : 0);
    end
    idle(HOLD + 3);
    chk("R6 phases idle", int'(phaseA) + int'(phaseB), 0);
    chk("R7 readEn idle", readEn, 1);

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule